// File: doc/BRIEF.md
# Serial LED Shift-Out Controller

This block feeds a chain of external serial-in/parallel-out shift registers with a 17-bit LED pattern. It produces a serial clock, a serial data line and a latch signal. The bit clock is a power-of-two fraction of the system clock. A programmable delay sets how far the clock edge trails the data change. After the last bit, a latch phase moves the shifted word onto the register outputs.

Software drives the block through a small word-wide register port. There are four locations: the pattern word, which also carries the busy flag; a divider code; a clock-delay value; and a mode word. The mode word chooses the latch polarity for the chip style and can turn on PWM mode. In PWM mode the pattern comes from a 17-bit channel vector supplied by a neighbouring PWM bank. A transfer is launched only when that vector changes to a non-zero value. Because of this, the chain has to be flushed with zeros from register mode before PWM mode is switched on.

Top module: `serial_led_shifter`

## Requirements
- R1: After reset, all reads return zero, except the divider location, which reads code 3. The sclk, sdata and latch outputs are low.
- R2: A write of the pattern location (address 0) while idle in register mode starts a transfer at once. The 17 bits go out most-significant first, one per sclk rising edge, and read bit 31 of address 0 becomes 1. Address 0 reads bit 31 as busy and bits 16:0 as the pattern.
- R3: Writes to any location while busy are ignored. The running transfer and all stored values stay unchanged.
- R4: Divider code c (address 1, bits 1:0) gives a serial clock period of N = 4·2^c system cycles. Each sclk high time lasts N/2 cycles.
- R5: Address 2 holds the delay minus one. Bit k (0 = first) begins k·N cycles after the write edge, and sclk rises D = min(value+1, N/2) cycles into that bit.
- R6: The latch phase follows the last bit and lasts one serial period. The latch is active for N/2 cycles starting D cycles into that phase. Busy reads 0 from 18·N cycles after the write edge.
- R7: Mode bit 0 (address 3) selects the chip style. With 0 the latch idles low and pulses high; with 1 it idles high and pulses low.
- R8: With mode bit 1 set, the channel vector is registered once. A transfer of that sample starts when the block is idle and the sample is non-zero and differs from the last pattern shifted.
- R9: In PWM mode, a sample that is all zeros or equal to the last pattern shifted starts no transfer. Pattern-location writes are ignored in this mode.
- R10: Register-mode transfers, including an all-zero flush, update the record of the last pattern shifted. That record is what PWM mode compares against.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write location |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read location |
| rd_data | output | 32 | Read data (combinational) |
| pwm_chan | input | 17 | Channel vector from the PWM bank |
| sclk | output | 1 | Serial clock to the chain |
| sdata | output | 1 | Serial data to the chain |
| latch | output | 1 | Latch/load to the chain, polarity per chip style |

## Verification
A corrupted bit index or shift register shows within one transfer: the captured word, or the count of 17 sclk rises, comes out wrong. A counter or delay error moves an sclk edge or the latch window. It is caught by cycle-exact comparison against the write edge, at most 18·N cycles after the write. A stale record of the last pattern shifted shows in PWM mode as a transfer that happens when none is due, or is missing when one is due. The bench watches for this for 40 cycles after each channel change.

// File: rtl/sled_pkg.sv
`timescale 1ns/1ps
package sled_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] RA_PATTERN = 2'd0;
    localparam logic [ADDR_W-1:0] RA_DIVSEL  = 2'd1;
    localparam logic [ADDR_W-1:0] RA_DELAY   = 2'd2;
    localparam logic [ADDR_W-1:0] RA_MODE    = 2'd3;

    localparam int MODE_STYLE_BIT = 0;
    localparam int MODE_PWM_BIT   = 1;

    typedef enum logic [1:0] {
        SL_IDLE  = 2'd0,
        SL_SHIFT = 2'd1,
        SL_LATCH = 2'd2
    } sled_phase_e;
endpackage

// File: rtl/sled_regs.sv
`timescale 1ns/1ps
module sled_regs
    import sled_pkg::*;
#(
    parameter int PAT_W    = 17,
    parameter int CODE_W   = 2,
    parameter int DLY_W    = 4,
    parameter int DATA_W   = 32,
    parameter int BUSY_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              busy_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [PAT_W-1:0]  pat_o,
    output logic [CODE_W-1:0] code_o,
    output logic [DLY_W-1:0]  dly_o,
    output logic              style_o,
    output logic              pwm_o,
    output logic              start_o
);
    typedef struct packed {
        logic [PAT_W-1:0]  pat;
        logic [CODE_W-1:0] code;
        logic [DLY_W-1:0]  dly;
        logic              style;
        logic              pwm;
    } regs_t;

    localparam regs_t REGS_RST = '{pat: '0, code: '1, dly: '0, style: 1'b0, pwm: 1'b0};

    regs_t d, q;
    logic  accept;

    always_comb begin
        d      = q;
        accept = wr_en_i && !busy_i;
        if (accept) begin
            case (wr_addr_i)
                RA_PATTERN: if (!q.pwm) d.pat = wr_data_i[PAT_W-1:0];
                RA_DIVSEL:  d.code = wr_data_i[CODE_W-1:0];
                RA_DELAY:   d.dly  = wr_data_i[DLY_W-1:0];
                default: begin
                    d.style = wr_data_i[MODE_STYLE_BIT];
                    d.pwm   = wr_data_i[MODE_PWM_BIT];
                end
            endcase
        end
        start_o = accept && (wr_addr_i == RA_PATTERN) && !q.pwm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            RA_PATTERN: begin
                rd_data_o[PAT_W-1:0] = q.pat;
                rd_data_o[BUSY_BIT]  = busy_i;
            end
            RA_DIVSEL: rd_data_o[CODE_W-1:0] = q.code;
            RA_DELAY:  rd_data_o[DLY_W-1:0]  = q.dly;
            default: begin
                rd_data_o[MODE_STYLE_BIT] = q.style;
                rd_data_o[MODE_PWM_BIT]   = q.pwm;
            end
        endcase
    end

    assign pat_o   = q.pat;
    assign code_o  = q.code;
    assign dly_o   = q.dly;
    assign style_o = q.style;
    assign pwm_o   = q.pwm;

    // R3: configuration is frozen for the whole transfer
    p_cfg_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(q.code) && $stable(q.dly) && $stable(q.style) && $stable(q.pwm)
                    && $stable(q.pat)));
endmodule

// File: rtl/sled_timer.sv
`timescale 1ns/1ps
module sled_timer #(
    parameter int CODE_W    = 2,
    parameter int DLY_W     = 4,
    parameter int BASE_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [DLY_W-1:0]  dly_i,
    output logic              per_end_o,
    output logic              win_o
);
    localparam int MAX_LOG2 = BASE_LOG2 + (1 << CODE_W) - 1;
    localparam int CW = (((MAX_LOG2 + 1) > (DLY_W + 1)) ? (MAX_LOG2 + 1) : (DLY_W + 1)) + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] period, half, dly_req, dly_eff, win_end;

    always_comb begin
        period    = CW'(1) << (CW'(BASE_LOG2) + CW'(code_i));
        half      = period >> 1;
        dly_req   = CW'(dly_i) + CW'(1);
        dly_eff   = (dly_req > half) ? half : dly_req;
        win_end   = dly_eff + half;
        per_end_o = run_i && (cnt_q == period - CW'(1));
        win_o     = run_i && (cnt_q >= dly_eff) && (cnt_q < win_end);
        cnt_d     = (!run_i || per_end_o) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the bit counter never leaves the selected period
    p_cnt_in_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < period));
endmodule

// File: rtl/sled_engine.sv
`timescale 1ns/1ps
module sled_engine
    import sled_pkg::*;
#(
    parameter int PAT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_start_i,
    input  logic [PAT_W-1:0] reg_pat_i,
    input  logic             pwm_mode_i,
    input  logic [PAT_W-1:0] pwm_chan_i,
    input  logic             per_end_i,
    input  logic             win_i,
    input  logic             style_i,
    output logic             busy_o,
    output logic             run_o,
    output logic             sclk_o,
    output logic             sdata_o,
    output logic             latch_o
);
    localparam int IDX_W = $clog2(PAT_W);

    typedef struct packed {
        sled_phase_e      phase;
        logic [PAT_W-1:0] sreg;
        logic [IDX_W-1:0] idx;
        logic [PAT_W-1:0] last;
        logic [PAT_W-1:0] smp;
    } eng_t;

    eng_t d, q;
    logic pwm_start;
    logic latch_act;

    always_comb begin
        d         = q;
        d.smp     = pwm_chan_i;
        pwm_start = pwm_mode_i && (q.phase == SL_IDLE) && (|q.smp) && (q.smp != q.last);
        case (q.phase)
            SL_IDLE: begin
                if (reg_start_i) begin
                    d.phase = SL_SHIFT;
                    d.sreg  = reg_pat_i;
                    d.last  = reg_pat_i;
                    d.idx   = IDX_W'(PAT_W - 1);
                end else if (pwm_start) begin
                    d.phase = SL_SHIFT;
                    d.sreg  = q.smp;
                    d.last  = q.smp;
                    d.idx   = IDX_W'(PAT_W - 1);
                end
            end
            SL_SHIFT: begin
                if (per_end_i) begin
                    if (q.idx == '0) begin
                        d.phase = SL_LATCH;
                    end else begin
                        d.sreg = {q.sreg[PAT_W-2:0], 1'b0};
                        d.idx  = q.idx - IDX_W'(1);
                    end
                end
            end
            SL_LATCH: begin
                if (per_end_i) d.phase = SL_IDLE;
            end
            default: d.phase = SL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        busy_o    = (q.phase != SL_IDLE);
        run_o     = busy_o;
        sclk_o    = (q.phase == SL_SHIFT) && win_i;
        sdata_o   = (q.phase == SL_SHIFT) && q.sreg[PAT_W-1];
        latch_act = (q.phase == SL_LATCH) && win_i;
        latch_o   = latch_act ^ style_i;
    end

    // R3: the register file only launches a transfer while the engine is idle
    p_reg_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_start_i |-> !busy_o);

    // R2: a launch makes the block busy with the pattern MSB on the data line
    p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_start_i |=> (busy_o && (sdata_o == $past(reg_pat_i[PAT_W-1]))));

    // R6: busy only ends out of the latch phase
    p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(q.phase) == SL_LATCH));

    // R9: a change-triggered launch never carries an all-zero word
    p_pwm_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_start && !reg_start_i) |=> (q.sreg != '0));
endmodule

// File: rtl/serial_led_shifter.sv
`timescale 1ns/1ps
module serial_led_shifter
    import sled_pkg::*;
#(
    parameter int PAT_W     = 17,
    parameter int CODE_W    = 2,
    parameter int DLY_W     = 4,
    parameter int BASE_LOG2 = 2,
    parameter int DATA_W    = 32,
    parameter int BUSY_BIT  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [PAT_W-1:0]  pwm_chan,
    output logic              sclk,
    output logic              sdata,
    output logic              latch
);
    logic [PAT_W-1:0]  pat;
    logic [CODE_W-1:0] code;
    logic [DLY_W-1:0]  dly;
    logic              style, pwm_mode, reg_start;
    logic              busy, run, per_end, win;

    sled_regs #(
        .PAT_W(PAT_W), .CODE_W(CODE_W), .DLY_W(DLY_W),
        .DATA_W(DATA_W), .BUSY_BIT(BUSY_BIT)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .busy_i(busy), .rd_data_o(rd_data),
        .pat_o(pat), .code_o(code), .dly_o(dly),
        .style_o(style), .pwm_o(pwm_mode), .start_o(reg_start)
    );

    sled_timer #(
        .CODE_W(CODE_W), .DLY_W(DLY_W), .BASE_LOG2(BASE_LOG2)
    ) i_timer (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .code_i(code), .dly_i(dly),
        .per_end_o(per_end), .win_o(win)
    );

    sled_engine #(
        .PAT_W(PAT_W)
    ) i_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_start_i(reg_start), .reg_pat_i(wr_data[PAT_W-1:0]),
        .pwm_mode_i(pwm_mode), .pwm_chan_i(pwm_chan),
        .per_end_i(per_end), .win_i(win), .style_i(style),
        .busy_o(busy), .run_o(run),
        .sclk_o(sclk), .sdata_o(sdata), .latch_o(latch)
    );
endmodule

// File: tb/test_serial_led_shifter.sv
`timescale 1ns/1ps
module test_serial_led_shifter;
    localparam int PW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic [PW-1:0] pwm_chan = '0;
    logic          sclk, sdata, latch;

    always #10 clk = ~clk;

    serial_led_shifter i_serial_led_shifter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_chan(pwm_chan), .sclk(sclk), .sdata(sdata), .latch(latch)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Port monitor, sampled on the falling edge
    logic          style_tb = 1'b0;
    logic          sclk_p = 1'b0, act_p = 1'b0;
    logic [PW-1:0] cap = '0;
    int rises = 0, last_rise = 0, prev_rise = 0, last_fall = 0, lat_on = 0, lat_off = 0;
    always @(negedge clk) begin
        if (sclk && !sclk_p) begin
            cap       <= {cap[PW-2:0], sdata};
            rises     <= rises + 1;
            prev_rise <= last_rise;
            last_rise <= cyc;
        end
        if (!sclk && sclk_p) last_fall <= cyc;
        if ((latch ^ style_tb) && !act_p) lat_on <= cyc;
        if (!(latch ^ style_tb) && act_p) lat_off <= cyc;
        sclk_p <= sclk;
        act_p  <= latch ^ style_tb;
    end

    int n_chk = 0, n_bad = 0;
    int t0 = 0, t_end = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(posedge clk);
        #1 t0 = cyc;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wait_idle();
        rd_addr = 2'd0;
        #1;
        while (rd_data[31]) begin
            @(negedge clk);
            #1;
        end
        t_end = cyc;
    endtask

    task automatic xfer(input logic [PW-1:0] pat, input int n, input int dd);
        int r0;
        r0 = rises;
        wr(2'd0, 32'(pat));
        wait_idle();
        @(negedge clk);
        chk("R2 shifted word", 32'(cap), 32'(pat));
        chk("R2 sclk rise count", 32'(rises - r0), 32'd17);
        chk("R4 sclk period", 32'(last_rise - prev_rise), 32'(n));
        chk("R4 sclk high time", 32'(last_fall - last_rise), 32'(n / 2));
        chk("R5 last rise offset", 32'(last_rise - t0), 32'(16 * n + dd));
        chk("R6 latch start", 32'(lat_on - t0), 32'(17 * n + dd));
        chk("R6 latch width", 32'(lat_off - lat_on), 32'(n / 2));
        chk("R6 busy clear", 32'(t_end - t0), 32'(18 * n));
    endtask

    task automatic no_xfer(input string tag);
        int r0;
        logic [31:0] v;
        r0 = rises;
        repeat (40) @(negedge clk);
        chk(tag, 32'(rises - r0), 32'd0);
        rd(2'd0, v);
        chk({tag, " busy"}, 32'(v[31]), 32'd0);
    endtask

    task automatic pwm_xfer(input logic [PW-1:0] pat);
        int r0, k;
        r0 = rises;
        @(negedge clk);
        pwm_chan = pat;
        rd_addr = 2'd0;
        k = 0;
        #1;
        while (!rd_data[31] && k < 20) begin
            @(negedge clk);
            #1;
            k++;
        end
        chk("R8 transfer launched", 32'(rd_data[31]), 32'd1);
        wait_idle();
        @(negedge clk);
        chk("R8 shifted channel word", 32'(cap), 32'(pat));
        chk("R8 sclk rise count", 32'(rises - r0), 32'd17);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk("R1 pattern reset", v, 32'h0);
        rd(2'd1, v); chk("R1 divider reset", v, 32'h3);
        rd(2'd2, v); chk("R1 delay reset", v, 32'h0);
        rd(2'd3, v); chk("R1 mode reset", v, 32'h0);
        chk("R1 outputs idle", {29'd0, sclk, sdata, latch}, 32'h0);
    endtask

    task automatic t_basic();
        wr(2'd1, 32'd1);
        wr(2'd2, 32'd0);
        xfer(17'h1A5C3, 8, 1);
        xfer(17'h0F0F0, 8, 1);
    endtask

    task automatic t_divider();
        wr(2'd1, 32'd0); wr(2'd2, 32'd1);
        xfer(17'h10001, 4, 2);
        wr(2'd1, 32'd2); wr(2'd2, 32'd7);
        xfer(17'h0FFFF, 16, 8);
        wr(2'd1, 32'd3); wr(2'd2, 32'd3);
        xfer(17'h15555, 32, 4);
    endtask

    task automatic t_clamp();
        logic [31:0] v;
        wr(2'd1, 32'd0); wr(2'd2, 32'd15);
        rd(2'd2, v); chk("R5 delay readback", v, 32'd15);
        xfer(17'h1C3A5, 4, 2);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        int r0;
        wr(2'd1, 32'd1); wr(2'd2, 32'd0);
        r0 = rises;
        wr(2'd0, 32'h12345);
        rd(2'd0, v);
        chk("R2 busy flag set", 32'(v[31]), 32'd1);
        chk("R2 pattern readback", 32'(v[16:0]), 32'h12345);
        wr(2'd0, 32'h0AAAA);
        wr(2'd1, 32'd3);
        wr(2'd3, 32'd1);
        wait_idle();
        @(negedge clk);
        chk("R3 transfer kept", 32'(cap), 32'h12345);
        chk("R3 rise count", 32'(rises - r0), 32'd17);
        rd(2'd0, v); chk("R3 pattern kept", v, 32'h12345);
        rd(2'd1, v); chk("R3 divider kept", v, 32'd1);
        rd(2'd3, v); chk("R3 mode kept", v, 32'd0);
    endtask

    task automatic t_style();
        wr(2'd3, 32'd1);
        style_tb = 1'b1;
        @(negedge clk);
        chk("R7 latch idles high", 32'(latch), 32'd1);
        xfer(17'h13579, 8, 1);
        wr(2'd3, 32'd0);
        style_tb = 1'b0;
        @(negedge clk);
        chk("R7 latch idles low", 32'(latch), 32'd0);
    endtask

    task automatic t_pwm();
        logic [31:0] v;
        xfer(17'h00000, 8, 1);
        pwm_chan = '0;
        wr(2'd3, 32'd2);
        no_xfer("R9 zero vector");
        pwm_xfer(17'h00A51);
        no_xfer("R9 unchanged vector");
        @(negedge clk); pwm_chan = '0;
        no_xfer("R9 return to zero");
        wr(2'd0, 32'h1FFFF);
        no_xfer("R9 pattern write in PWM mode");
        rd(2'd0, v); chk("R9 pattern unchanged", v, 32'h0);
        pwm_xfer(17'h1E00F);
        wr(2'd3, 32'd0);
    endtask

    task automatic t_last();
        xfer(17'h00777, 8, 1);
        @(negedge clk); pwm_chan = 17'h00777;
        wr(2'd3, 32'd2);
        no_xfer("R10 matches register-mode word");
        pwm_xfer(17'h00778);
        wr(2'd3, 32'd0);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_basic();
                t_divider();
                t_clamp();
                t_busy();
                t_style();
                t_pwm();
                t_last();
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule